// File: doc/BRIEF.md
# Stepper Step/Direction Command Sequencer

This block turns a move request from a host into the control-line waveform that an external microstepping motor driver expects. The host presents a step count, a rotation direction, a two-bit resolution code and a requested step period in system clocks, then strobes a start input. The block places the direction and the two microstep-select lines and waits out the driver's setup time. It then emits the requested number of step pulses. Each pulse has a fixed minimum active width and a minimum inactive gap. The step rate is capped at the driver's maximum. After the last pulse the command lines stay unchanged for the hold time, and the block then signals completion.

All driver timing limits are given in nanoseconds and converted to whole system clocks, rounding up, from a clock-rate parameter (clocks per microsecond). A second parameter picks the electrical sense of the active-level lines: active-low for an open-collector (sinking) hookup, active-high for a sourcing hookup. A synchronous abort cuts a move short without ever producing a truncated pulse. A separate enable input drives the driver's output-disable line.

Top module: `stepseq_top`

## Requirements
- R1: While reset is asserted and right after it, step, select and disable lines sit at their inactive, inactive and active levels respectively, direction is 0, and busy and done are 0.
- R2: Resolution code res_i is 0 = full, 1 = half, 2 = quarter, 3 = eighth step. MS1 is active for codes 0 and 2 (res_i[0] = 0). MS2 is active for codes 0 and 1 (res_i[1] = 0). The select lines take the new code in the cycle after an accepted start.
- R3: dir_o is a plain logic level, 1 for clockwise and 0 for counter-clockwise, whatever the polarity mode. It follows dir_i of the accepted command.
- R4: With SINKING = 1 an active step, select or disable line is driven 0. With SINKING = 0 it is driven 1.
- R5: The first step pulse goes active exactly SETUP_CLKS = ceil(200 ns) clocks after the command lines take their new values.
- R6: Every step pulse is active for exactly PW_CLKS = ceil(1000 ns) clocks.
- R7: Successive pulse rising edges are max(period_i, MINP_CLKS) clocks apart, with MINP_CLKS = ceil(2000 ns). The gap is therefore at least ceil(1000 ns).
- R8: A non-aborted move emits exactly count_i pulses.
- R9: After the final pulse ends, done rises no sooner than HOLD_CLKS = ceil(200 ns) clocks later, exactly HOLD_CLKS for a normal end. Direction and select lines do not change in that window.
- R10: A start with count_i = 0 raises done in the next cycle, emits no pulse and never raises busy.
- R11: Start is ignored while busy. Direction and select lines never change while busy.
- R12: An abort during a pulse lets that pulse finish its full width. An abort during the setup wait or a gap moves straight to the hold wait. No pulse follows an abort, and done follows after the hold wait.
- R13: off_o is active when motor_en_i is 0 and inactive when it is 1, one clock after the input.
- R14: Busy is 1 from the cycle after an accepted non-zero start until the cycle done pulses. Done is a single-cycle pulse during which busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| start_i | input | 1 | Start strobe, taken only while idle |
| count_i | input | COUNT_W | Number of steps to send |
| dir_i | input | 1 | Direction, 1 clockwise |
| res_i | input | 2 | Resolution code (0 full .. 3 eighth) |
| period_i | input | PERIOD_W | Requested step period in clocks |
| abort_i | input | 1 | Synchronous abort of the current move |
| motor_en_i | input | 1 | 1 enables the driver output stage |
| step_o | output | 1 | Step clock line to the driver |
| dir_o | output | 1 | Direction line to the driver |
| ms1_o | output | 1 | Microstep select line 1 |
| ms2_o | output | 1 | Microstep select line 2 |
| off_o | output | 1 | Driver output-disable line |
| busy_o | output | 1 | A move is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a move |

## Verification
The sharpest collision is an abort arriving in the very clock where the last pulse of a move reaches its minimum width. The natural end of the move and the abort then both want to close the pulse and start the hold wait. The bench provokes this with a single-step move. It watches for the rising step edge, counts PW_CLKS - 1 further clocks and raises abort for that one cycle. The outcome passes only if exactly one full-width pulse appears, exactly one done follows exactly HOLD_CLKS after the pulse ends, and the select lines stay put throughout. A second collision, a start arriving while a move is in progress, is driven mid-pulse with a different direction and count, and is judged by the unchanged lines and pulse count.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_GAP   = 3'd3,
    ST_HOLD  = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    RES_FULL    = 2'd0,
    RES_HALF    = 2'd1,
    RES_QUARTER = 2'd2,
    RES_EIGHTH  = 2'd3
  } res_code_e;

  // Driver limits in nanoseconds
  localparam int unsigned SETUP_NS   = 200;
  localparam int unsigned HOLD_NS    = 200;
  localparam int unsigned PULSE_NS   = 1000;
  localparam int unsigned GAP_NS     = 1000;
  localparam int unsigned MIN_PER_NS = 2000;

  // Nanoseconds to clocks, rounded up, never below one clock
  function automatic int unsigned ns_to_clks(input int unsigned ns,
                                             input int unsigned clk_mhz);
    int unsigned c;
    c = (ns * clk_mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/stepseq_timer.sv
module stepseq_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_en && (cnt_q != '0)) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/stepseq_res_enc.sv
module stepseq_res_enc
  import stepseq_pkg::*;
(
  input  logic [1:0] res,
  output logic [1:0] sel_act   // [0] = MS1 active, [1] = MS2 active
);

  always_comb begin
    unique case (res_code_e'(res))
      RES_FULL:    sel_act = 2'b11;
      RES_HALF:    sel_act = 2'b10;
      RES_QUARTER: sel_act = 2'b01;
      RES_EIGHTH:  sel_act = 2'b00;
      default:     sel_act = 2'b00;
    endcase
  end

endmodule

// File: rtl/stepseq_period_clamp.sv
module stepseq_period_clamp #(
  parameter int unsigned W        = 16,
  parameter int unsigned MIN_PER  = 100,
  parameter int unsigned PW       = 50
) (
  input  logic [W-1:0] req_period,
  output logic [W-1:0] gap_len
);

  localparam logic [W-1:0] MIN_PER_V = W'(MIN_PER);
  localparam logic [W-1:0] PW_V      = W'(PW);

  logic [W-1:0] eff_period;

  always_comb begin
    eff_period = (req_period < MIN_PER_V) ? MIN_PER_V : req_period;
    gap_len    = eff_period - PW_V;
  end

endmodule

// File: rtl/stepseq_pin_drv.sv
module stepseq_pin_drv #(
  parameter int unsigned N       = 4,
  parameter bit          SINKING = 1'b1
) (
  input  logic [N-1:0] act,
  output logic [N-1:0] pin
);

  for (genvar i = 0; i < N; i++) begin : g_line
    if (SINKING) begin : g_sink
      assign pin[i] = ~act[i];
    end else begin : g_source
      assign pin[i] = act[i];
    end
  end

endmodule

// File: rtl/stepseq_top.sv
module stepseq_top
  import stepseq_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 50,
  parameter bit          SINKING  = 1'b1,
  parameter int unsigned COUNT_W  = 16,
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [COUNT_W-1:0]  count_i,
  input  logic                dir_i,
  input  logic [1:0]          res_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                abort_i,
  input  logic                motor_en_i,
  output logic                step_o,
  output logic                dir_o,
  output logic                ms1_o,
  output logic                ms2_o,
  output logic                off_o,
  output logic                busy_o,
  output logic                done_o
);

  localparam int unsigned SETUP_CLKS = ns_to_clks(SETUP_NS, CLK_MHZ);
  localparam int unsigned HOLD_CLKS  = ns_to_clks(HOLD_NS, CLK_MHZ);
  localparam int unsigned PW_CLKS    = ns_to_clks(PULSE_NS, CLK_MHZ);
  localparam int unsigned GAP_CLKS   = ns_to_clks(GAP_NS, CLK_MHZ);
  localparam int unsigned MINP_CLKS  = umax(ns_to_clks(MIN_PER_NS, CLK_MHZ),
                                            PW_CLKS + GAP_CLKS);

  localparam logic [PERIOD_W-1:0] SETUP_LD = PERIOD_W'(SETUP_CLKS - 1);
  localparam logic [PERIOD_W-1:0] HOLD_LD  = PERIOD_W'(HOLD_CLKS - 1);
  localparam logic [PERIOD_W-1:0] PULSE_LD = PERIOD_W'(PW_CLKS - 1);
  localparam logic [COUNT_W-1:0]  ONE_STEP = COUNT_W'(1);
  localparam int unsigned         NPIN     = 4;

  seq_state_e          state_q, state_d;
  logic [COUNT_W-1:0]  rem_q, rem_d;
  logic [PERIOD_W-1:0] gap_q;
  logic [PERIOD_W-1:0] gap_new;
  logic                dir_q;
  logic [1:0]          sel_q;
  logic [1:0]          sel_new;
  logic                step_act_q, step_act_d;
  logic                done_q, done_d;
  logic                pend_q, pend_d;
  logic                off_act_q;
  logic                cmd_ld;
  logic                tmr_ld;
  logic [PERIOD_W-1:0] tmr_val;
  logic                tmr_en;
  logic                tmr_zero;
  logic [NPIN-1:0]     pin_act;
  logic [NPIN-1:0]     pin_lvl;

  // ---------------------------------------------------------------
  // Sub-blocks
  // ---------------------------------------------------------------
  stepseq_res_enc u_res (
    .res     (res_i),
    .sel_act (sel_new)
  );

  stepseq_period_clamp #(
    .W       (PERIOD_W),
    .MIN_PER (MINP_CLKS),
    .PW      (PW_CLKS)
  ) u_clamp (
    .req_period (period_i),
    .gap_len    (gap_new)
  );

  assign tmr_en = (state_q != ST_IDLE);

  stepseq_timer #(
    .W (PERIOD_W)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (tmr_en),
    .load     (tmr_ld),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // ---------------------------------------------------------------
  // Sequencer next state
  // ---------------------------------------------------------------
  always_comb begin
    state_d    = state_q;
    rem_d      = rem_q;
    step_act_d = step_act_q;
    done_d     = 1'b0;
    pend_d     = pend_q;
    cmd_ld     = 1'b0;
    tmr_ld     = 1'b0;
    tmr_val    = '0;

    unique case (state_q)
      ST_IDLE: begin
        pend_d = 1'b0;
        if (start_i) begin
          if (count_i == '0) begin
            done_d = 1'b1;
          end else begin
            cmd_ld  = 1'b1;
            rem_d   = count_i;
            state_d = ST_SETUP;
            tmr_ld  = 1'b1;
            tmr_val = SETUP_LD;
          end
        end
      end

      ST_SETUP: begin
        if (abort_i) begin
          state_d = ST_HOLD;
          tmr_ld  = 1'b1;
          tmr_val = HOLD_LD;
        end else if (tmr_zero) begin
          state_d    = ST_PULSE;
          step_act_d = 1'b1;
          tmr_ld     = 1'b1;
          tmr_val    = PULSE_LD;
        end
      end

      ST_PULSE: begin
        if (abort_i) begin
          pend_d = 1'b1;
        end
        if (tmr_zero) begin
          step_act_d = 1'b0;
          rem_d      = rem_q - ONE_STEP;
          tmr_ld     = 1'b1;
          if ((rem_q == ONE_STEP) || abort_i || pend_q) begin
            state_d = ST_HOLD;
            tmr_val = HOLD_LD;
          end else begin
            state_d = ST_GAP;
            tmr_val = gap_q - PERIOD_W'(1);
          end
        end
      end

      ST_GAP: begin
        if (abort_i) begin
          state_d = ST_HOLD;
          tmr_ld  = 1'b1;
          tmr_val = HOLD_LD;
        end else if (tmr_zero) begin
          state_d    = ST_PULSE;
          step_act_d = 1'b1;
          tmr_ld     = 1'b1;
          tmr_val    = PULSE_LD;
        end
      end

      ST_HOLD: begin
        if (tmr_zero) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end

      default: begin
        state_d    = ST_IDLE;
        step_act_d = 1'b0;
      end
    endcase
  end

  // ---------------------------------------------------------------
  // Registers
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rem_q      <= '0;
      step_act_q <= 1'b0;
      done_q     <= 1'b0;
      pend_q     <= 1'b0;
      off_act_q  <= 1'b1;
    end else begin
      state_q    <= state_d;
      rem_q      <= rem_d;
      step_act_q <= step_act_d;
      done_q     <= done_d;
      pend_q     <= pend_d;
      off_act_q  <= ~motor_en_i;
    end
  end

  // Command lines: loaded only on an accepted start (clock enable cmd_ld)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      sel_q <= 2'b00;
      gap_q <= '0;
    end else if (cmd_ld) begin
      dir_q <= dir_i;
      sel_q <= sel_new;
      gap_q <= gap_new;
    end
  end

  // ---------------------------------------------------------------
  // Output polarity
  // ---------------------------------------------------------------
  assign pin_act = {off_act_q, sel_q[1], sel_q[0], step_act_q};

  stepseq_pin_drv #(
    .N       (NPIN),
    .SINKING (SINKING)
  ) u_pins (
    .act (pin_act),
    .pin (pin_lvl)
  );

  assign step_o = pin_lvl[0];
  assign ms1_o  = pin_lvl[1];
  assign ms2_o  = pin_lvl[2];
  assign off_o  = pin_lvl[3];
  assign dir_o  = dir_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

endmodule

// File: rtl/stepseq_chk.sv
module stepseq_chk
  import stepseq_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 50,
  parameter bit          SINKING  = 1'b1,
  parameter int unsigned COUNT_W  = 16,
  parameter int unsigned PERIOD_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic [COUNT_W-1:0]  count_i,
  input logic                dir_i,
  input logic [1:0]          res_i,
  input logic [PERIOD_W-1:0] period_i,
  input logic                abort_i,
  input logic                motor_en_i,
  input logic                step_o,
  input logic                dir_o,
  input logic                ms1_o,
  input logic                ms2_o,
  input logic                off_o,
  input logic                busy_o,
  input logic                done_o
);

  localparam int unsigned SETUP_CLKS = ns_to_clks(SETUP_NS, CLK_MHZ);
  localparam int unsigned HOLD_CLKS  = ns_to_clks(HOLD_NS, CLK_MHZ);
  localparam int unsigned PW_CLKS    = ns_to_clks(PULSE_NS, CLK_MHZ);
  localparam int unsigned GAP_CLKS   = ns_to_clks(GAP_NS, CLK_MHZ);

  logic        step_act;
  logic [2:0]  lines;
  logic [2:0]  lines_prev;
  logic [15:0] hi_cnt;
  logic [15:0] lo_cnt;
  logic [15:0] age;
  logic        pulsed;

  assign step_act = SINKING ? ~step_o : step_o;
  assign lines    = {dir_o, ms2_o, ms1_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt     <= '0;
      lo_cnt     <= '0;
      age        <= '0;
      lines_prev <= '0;
      pulsed     <= 1'b0;
    end else begin
      hi_cnt     <= step_act ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1) : 16'd0;
      lo_cnt     <= step_act ? 16'd0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1);
      age        <= (lines != lines_prev) ? 16'd0 :
                    ((age == 16'hFFFF) ? age : age + 16'd1);
      lines_prev <= lines;
      if (done_o)        pulsed <= 1'b0;
      else if (step_act) pulsed <= 1'b1;
    end
  end

  // R6: every pulse ends at exactly the minimum width
  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step_act) && !step_act) |-> (hi_cnt == 16'(PW_CLKS)));

  // R7: gap between pulses of one move never below the minimum
  a_r7_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_act && !$past(step_act) && pulsed) |-> (lo_cnt >= 16'(GAP_CLKS)));

  // R5: lines were stable for age+1 clocks when the step goes active
  a_r5_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (step_act && !$past(step_act)) |-> (age >= 16'(SETUP_CLKS - 1)));

  // R9: done comes no sooner than the hold time after the last pulse
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && pulsed) |-> (lo_cnt >= 16'(HOLD_CLKS)));

  // R11: command lines frozen while a move runs
  a_r11_lines_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(lines));

  // R14: done and busy never together; step only while busy
  a_r14_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r14_step_in_move: assert property (@(posedge clk) disable iff (!rst_n)
    step_act |-> busy_o);

  // R10: zero-count start completes at once
  a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (count_i == '0)) |=> (done_o && !busy_o));

  // R2: select lines encode the accepted resolution
  a_r2_sel_encode: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (count_i != '0)) |=>
      ((ms1_o == (SINKING ? $past(res_i[0]) : ~$past(res_i[0]))) &&
       (ms2_o == (SINKING ? $past(res_i[1]) : ~$past(res_i[1])))));

  // R3: direction follows the accepted command
  a_r3_dir_level: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (count_i != '0)) |=> (dir_o == $past(dir_i)));

  // R13: disable line follows the enable input one clock later
  a_r13_off_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (off_o == (SINKING ? $past(motor_en_i) : ~$past(motor_en_i))));

  // R12: no new pulse starts in the cycle after an abort is seen
  a_r12_abort_no_new: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && busy_o && !step_act) |=> !step_act);

  logic unused_ok;
  assign unused_ok = ^{period_i};

endmodule

bind stepseq_top stepseq_chk #(
  .CLK_MHZ  (CLK_MHZ),
  .SINKING  (SINKING),
  .COUNT_W  (COUNT_W),
  .PERIOD_W (PERIOD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .count_i    (count_i),
  .dir_i      (dir_i),
  .res_i      (res_i),
  .period_i   (period_i),
  .abort_i    (abort_i),
  .motor_en_i (motor_en_i),
  .step_o     (step_o),
  .dir_o      (dir_o),
  .ms1_o      (ms1_o),
  .ms2_o      (ms2_o),
  .off_o      (off_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/sim_stepseq_top.sv
`timescale 1ns/1ps
module sim_stepseq_top;

  localparam int unsigned CLK_MHZ  = 50;
  localparam bit          SINKING  = 1'b1;
  localparam int unsigned COUNT_W  = 16;
  localparam int unsigned PERIOD_W = 16;

  // Expected clock counts from the requirements (ceil of ns * MHz / 1000)
  localparam int SETUP = (200  * CLK_MHZ + 999) / 1000;
  localparam int HOLD  = (200  * CLK_MHZ + 999) / 1000;
  localparam int PW    = (1000 * CLK_MHZ + 999) / 1000;
  localparam int MINP  = (2000 * CLK_MHZ + 999) / 1000;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                start_i;
  logic [COUNT_W-1:0]  count_i;
  logic                dir_i;
  logic [1:0]          res_i;
  logic [PERIOD_W-1:0] period_i;
  logic                abort_i;
  logic                motor_en_i;
  logic                step_o, dir_o, ms1_o, ms2_o, off_o, busy_o, done_o;

  stepseq_top #(
    .CLK_MHZ (CLK_MHZ), .SINKING (SINKING),
    .COUNT_W (COUNT_W), .PERIOD_W (PERIOD_W)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .count_i (count_i),
    .dir_i (dir_i), .res_i (res_i), .period_i (period_i), .abort_i (abort_i),
    .motor_en_i (motor_en_i), .step_o (step_o), .dir_o (dir_o),
    .ms1_o (ms1_o), .ms2_o (ms2_o), .off_o (off_o), .busy_o (busy_o),
    .done_o (done_o)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;

  function automatic logic lvl(input logic act);
    return SINKING ? ~act : act;
  endfunction

  function automatic int eff_period(input int req);
    return (req < MINP) ? MINP : req;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- output monitor (samples at falling edge) ----------
  int   cyc = 0;
  int   npulse, width_bad, per_bad, done_cnt, busy_rises, line_moves;
  int   busy_start, first_rise, last_rise, last_fall, done_cyc, busy_at_done;
  int   exp_per_cur;
  logic [2:0] lines_ref;
  logic prev_act, prev_busy;
  logic mon_act;
  assign mon_act = SINKING ? ~step_o : step_o;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_act  <= 1'b0;
      prev_busy <= 1'b0;
    end else begin
      if (busy_o && !prev_busy) begin
        busy_rises++;
        busy_start = cyc;
        lines_ref  = {dir_o, ms1_o, ms2_o};
      end
      if (busy_o && prev_busy && ({dir_o, ms1_o, ms2_o} != lines_ref))
        line_moves++;
      if (mon_act && !prev_act) begin
        if (npulse == 0) first_rise = cyc;
        else if (cyc - last_rise != exp_per_cur) per_bad++;
        last_rise = cyc;
        npulse++;
      end
      if (!mon_act && prev_act) begin
        if (cyc - last_rise != PW) width_bad++;
        last_fall = cyc;
      end
      if (done_o) begin
        done_cnt++;
        done_cyc     = cyc;
        busy_at_done = busy_o;
      end
      prev_act  <= mon_act;
      prev_busy <= busy_o;
    end
  end

  // ---------------- one move ----------------
  // mode: 0 none, 1 abort mid pulse #arg, 2 abort in gap after pulse #arg,
  //       3 abort in setup, 4 abort in last cycle of the single pulse,
  //       5 second start while busy
  task automatic run_cmd(input int cnt, input logic d, input logic [1:0] r,
                         input int per, input int mode, input int arg,
                         input int exp_np, input string tag);
    int start_cyc;
    int abort_cyc;
    bit fired;
    int guard;
    @(negedge clk); #2;
    npulse = 0; width_bad = 0; per_bad = 0; done_cnt = 0; busy_rises = 0;
    line_moves = 0; first_rise = 0; last_rise = 0; last_fall = 0;
    done_cyc = 0; busy_start = 0; busy_at_done = 0;
    exp_per_cur = eff_period(per);
    start_cyc = cyc;
    abort_cyc = 0;
    fired = 1'b0;
    start_i = 1'b1; count_i = COUNT_W'(cnt); dir_i = d; res_i = r;
    period_i = PERIOD_W'(per);
    guard = 0;
    while (done_cnt == 0 && guard < 20000) begin
      @(negedge clk); #2;
      guard++;
      start_i = 1'b0; abort_i = 1'b0;
      dir_i = d; res_i = r; count_i = COUNT_W'(cnt);
      if (done_cnt == 0 && !fired) begin
        if ((mode == 1 && npulse == arg && mon_act && cyc == last_rise + 5) ||
            (mode == 2 && npulse == arg && !mon_act && last_fall > last_rise &&
             cyc == last_fall + 3) ||
            (mode == 3 && cyc == start_cyc + 3) ||
            (mode == 4 && npulse == 1 && mon_act && cyc == last_rise + PW - 1)) begin
          abort_i = 1'b1; abort_cyc = cyc; fired = 1'b1;
        end else if (mode == 5 && cyc == start_cyc + 20) begin
          start_i = 1'b1; dir_i = ~d; res_i = ~r; count_i = COUNT_W'(9);
          fired = 1'b1;
        end
      end
    end
    @(negedge clk); #2;
    abort_i = 1'b0; start_i = 1'b0;
    chk(guard < 20000, {tag, " R14 move completes"}, guard, 0);
    chk(done_cnt == 1 && done_o == 1'b0, {tag, " R14 single done pulse"}, done_cnt, 1);
    chk(busy_at_done == 0, {tag, " R14 busy low at done"}, busy_at_done, 0);
    chk(npulse == exp_np, {tag, " R8/R12 pulse count"}, npulse, exp_np);
    chk(width_bad == 0, {tag, " R6 pulse width"}, width_bad, 0);
    chk(per_bad == 0, {tag, " R7 step period"}, per_bad, 0);
    if (cnt == 0) begin
      chk(done_cyc == start_cyc + 1, {tag, " R10 immediate done"}, done_cyc - start_cyc, 1);
      chk(busy_rises == 0, {tag, " R10 busy stays low"}, busy_rises, 0);
    end else begin
      chk(busy_start == start_cyc + 1, {tag, " R14 busy start"}, busy_start - start_cyc, 1);
      chk(line_moves == 0, {tag, " R11 lines frozen"}, line_moves, 0);
      chk(lines_ref[2] == d, {tag, " R3 direction level"}, lines_ref[2], d);
      chk(lines_ref[1] == lvl(~r[0]), {tag, " R2 MS1 level"}, lines_ref[1], lvl(~r[0]));
      chk(lines_ref[0] == lvl(~r[1]), {tag, " R2 MS2 level"}, lines_ref[0], lvl(~r[1]));
      if (npulse > 0)
        chk(first_rise - busy_start == SETUP, {tag, " R5 setup time"},
            first_rise - busy_start, SETUP);
      if (mode == 2 || mode == 3)
        chk(done_cyc == abort_cyc + HOLD + 1, {tag, " R12 abort to done"},
            done_cyc - abort_cyc, HOLD + 1);
      else
        chk(done_cyc - last_fall == HOLD, {tag, " R9 hold time"},
            done_cyc - last_fall, HOLD);
    end
  endtask

  // ---------------- stimulus ----------------
  bit finished = 1'b0;

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; start_i = 1'b0; count_i = '0; dir_i = 1'b0; res_i = 2'd0;
    period_i = '0; abort_i = 1'b0; motor_en_i = 1'b0;
    repeat (4) @(negedge clk);
    // R1 / R4: reset levels (active-low lines in sinking mode)
    chk(step_o == lvl(1'b0), "R1 R4 step inactive in reset", step_o, lvl(1'b0));
    chk(off_o == lvl(1'b1), "R1 off active in reset", off_o, lvl(1'b1));
    chk(ms1_o == lvl(1'b0) && ms2_o == lvl(1'b0), "R1 select inactive",
        {ms1_o, ms2_o}, {lvl(1'b0), lvl(1'b0)});
    chk(dir_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, "R1 dir busy done low",
        {dir_o, busy_o, done_o}, 0);
    #2 rst_n = 1'b1;
    @(negedge clk); #2;
    chk(step_o == lvl(1'b0) && busy_o == 1'b0, "R1 idle after reset", busy_o, 0);

    // R13: enable to disable line, one clock later
    motor_en_i = 1'b1;
    @(negedge clk); #2;
    chk(off_o == lvl(1'b0), "R13 off inactive when enabled", off_o, lvl(1'b0));
    motor_en_i = 1'b0;
    @(negedge clk); #2;
    chk(off_o == lvl(1'b1), "R13 off active when disabled", off_o, lvl(1'b1));
    motor_en_i = 1'b1;

    run_cmd(0, 1'b1, 2'd1, 150, 0, 0, 0, "zero count");            // R10
    run_cmd(3, 1'b1, 2'd3, 1,   0, 0, 3, "clamped period");         // R7
    run_cmd(2, 1'b0, 2'd0, MINP, 0, 0, 2, "full step ccw");          // R2
    run_cmd(2, 1'b1, 2'd1, 130, 0, 0, 2, "half step cw");
    run_cmd(2, 1'b0, 2'd2, 101, 0, 0, 2, "quarter step");
    run_cmd(1, 1'b1, 2'd3, 0,   0, 0, 1, "single eighth");
    run_cmd(8, 1'b1, 2'd2, 150, 1, 2, 2, "abort mid pulse");         // R12
    run_cmd(8, 1'b0, 2'd1, 150, 2, 1, 1, "abort in gap");            // R12
    run_cmd(8, 1'b1, 2'd0, 150, 3, 0, 0, "abort in setup");          // R12
    run_cmd(1, 1'b0, 2'd3, 200, 4, 0, 1, "abort on final edge");     // R12 R9
    run_cmd(3, 1'b0, 2'd1, 120, 5, 0, 3, "start while busy");        // R11

    for (int i = 0; i < 10; i++) begin
      int c = 1 + int'($urandom % 4);
      int p = int'($urandom % 320);
      run_cmd(c, 1'($urandom % 2), 2'($urandom % 4), p, 0, 0, c, "random move");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule